// File: doc/BRIEF.md
# Cycle Trace Log Ring Buffer

A debug recorder that stores one 256-bit trace record on every clock cycle into a circular on-chip RAM of `DEPTH` entries. Two register masters, a software port and a debug port, each see the same pair of 64-bit registers. The control register (select 0) reports the write position and the buffer length in its upper half. It holds this port's freeze flag and read cursor in its lower half. The data register (select 1) hands out the log one 64-bit lane at a time and steps the cursor on each read.

To take a log, a master sets its freeze flag, loads its read cursor and then reads the data register repeatedly. Either master can hold the log still. Each keeps its own cursor, so both can walk the buffer at the same time. Setting `DEPTH` to zero removes the storage and disables logging.

Top module: `trace_ring_log`

## Requirements
- R1: On each clock edge at which logging is not frozen, `rec_in` is stored at entry `wptr` and `wptr` steps by one, going from `DEPTH-1` back to 0.
- R2: A control read returns `DEPTH | wptr` in bits 63:32, where `wptr` is the value it had in the request cycle. Because `DEPTH` is a power of two, its highest set bit sits at bit 32+log2(DEPTH).
- R3: In a control read, bit 31 is the requesting port's freeze flag and bits 30:0 its read cursor in doublewords. Cursor value r addresses entry r/4 and lane r%4, and lane j is record bits 64j+63:64j.
- R4: A data read (select 1, write 0) returns the doubleword at the cursor and then adds one to the cursor, which wraps from 4*DEPTH-1 to 0.
- R5: A control write loads the freeze flag from wdata bit 31 and the cursor from wdata bits 30:0, taken modulo 4*DEPTH. Wdata bits 63:32 have no effect on `wptr`, and a write to the data register changes nothing.
- R6: Logging is frozen while either port's freeze flag is set. A freeze write does not stop the record stored at its own edge, and logging resumes on the edge after the last flag is cleared.
- R7: `rdata` and `rvalid` appear in the cycle after a read request. `rvalid` is low in every cycle that does not follow a read.
- R8: The two ports keep separate cursors and freeze flags, and they may both read in the same cycle without affecting each other.
- R9: With `DEPTH` = 0, nothing is logged, control reads return zero in bits 63:32, and data reads return zero.
- R10: Synchronous reset clears `wptr`, both cursors, both freeze flags and both `rvalid` outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_in | input | 256 | Trace record offered each cycle |
| sw_req | input | 1 | Software port access strobe |
| sw_we | input | 1 | Software port write (1) or read (0) |
| sw_sel | input | 1 | Software port register: 0 control, 1 data |
| sw_wdata | input | 64 | Software port write data |
| sw_rdata | output | 64 | Software port read data |
| sw_rvalid | output | 1 | Software port read data valid |
| dbg_req | input | 1 | Debug port access strobe |
| dbg_we | input | 1 | Debug port write (1) or read (0) |
| dbg_sel | input | 1 | Debug port register: 0 control, 1 data |
| dbg_wdata | input | 64 | Debug port write data |
| dbg_rdata | output | 64 | Debug port read data |
| dbg_rvalid | output | 1 | Debug port read data valid |

## Verification
Two pairs of events can fall on the same edge. The first pair is a freeze write and a record store: the bench freezes and releases the log with a known number of idle edges in between, then checks the exact advance of the write position and reads back the record stored on the freezing edge. The second pair is data reads from both ports. The bench points the two cursors at different lanes, reads from both ports in the same cycles, and compares each result with a model memory that it fills from its own record generator.

// File: rtl/trace_log_pkg.sv
package trace_log_pkg;
  localparam int LANE_W  = 64;
  localparam int LANES   = 4;
  localparam int REC_W   = LANE_W * LANES;
  localparam int LSEL_W  = 2;
  localparam int HALF_W  = 32;
  localparam int FRZ_BIT = 31;
  localparam int NPORT   = 2;

  typedef enum logic {
    SEL_CTL  = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/trace_log_ram.sv
module trace_log_ram #(
  parameter int WORDS = 2048,
  parameter int AW    = 11,
  parameter int DW    = 256
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  // write port: one full record per cycle
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read, old data on a same-address collision
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trace_log_wptr.sv
module trace_log_wptr #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  output logic [AW-1:0] wptr,
  output logic [31:0]   wfield
);
  generate
    if (DEPTH > 0) begin : g_on
      localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
      always_ff @(posedge clk) begin
        if (rst)        wptr <= '0;
        else if (!hold) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      end
      // length bit sits just above the live pointer bits
      assign wfield = 32'(DEPTH) | 32'(wptr);
    end else begin : g_off
      logic unused_off;
      assign unused_off = clk ^ rst ^ hold;
      assign wptr   = '0;
      assign wfield = '0;
    end
  endgenerate
endmodule

// File: rtl/trace_log_port.sv
module trace_log_port
  import trace_log_pkg::*;
#(
  parameter int AW  = 11,
  parameter int RPW = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  reg_sel_e          sel,
  input  logic [LANE_W-1:0] wdata,
  input  logic [31:0]       wfield,
  input  logic [REC_W-1:0]  ram_q,
  output logic              frz,
  output logic              ram_re,
  output logic [AW-1:0]     ram_raddr,
  output logic [LANE_W-1:0] rdata,
  output logic              rvalid
);
  logic [RPW-1:0]    rptr;
  logic [LSEL_W-1:0] lane_q;
  logic              is_data_q;
  logic [LANE_W-1:0] ctl_q;
  logic              rd_data, rd_ctl, wr_ctl;
  logic [LANE_W-1:0] lane_word;
  logic              unused_wd;

  assign unused_wd = ^wdata;

  assign rd_data = req && !we && (sel == SEL_DATA);
  assign rd_ctl  = req && !we && (sel == SEL_CTL);
  assign wr_ctl  = req &&  we && (sel == SEL_CTL);

  assign ram_re    = rd_data;
  assign ram_raddr = rptr[RPW-1:LSEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr      <= '0;
      frz       <= 1'b0;
      lane_q    <= '0;
      is_data_q <= 1'b0;
      ctl_q     <= '0;
      rvalid    <= 1'b0;
    end else begin
      rvalid <= rd_data || rd_ctl;
      if (wr_ctl) begin
        frz  <= wdata[FRZ_BIT];
        rptr <= wdata[RPW-1:0];
      end
      if (rd_data) begin
        lane_q    <= rptr[LSEL_W-1:0];
        is_data_q <= 1'b1;
        rptr      <= rptr + 1'b1;
      end
      if (rd_ctl) begin
        ctl_q     <= {wfield, frz, 31'(rptr)};
        is_data_q <= 1'b0;
      end
    end
  end

  assign lane_word = ram_q[LANE_W*lane_q +: LANE_W];
  assign rdata     = is_data_q ? lane_word : ctl_q;
endmodule

// File: rtl/trace_ring_log.sv
module trace_ring_log
  import trace_log_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REC_W-1:0]  rec_in,
  input  logic              sw_req,
  input  logic              sw_we,
  input  logic              sw_sel,
  input  logic [LANE_W-1:0] sw_wdata,
  output logic [LANE_W-1:0] sw_rdata,
  output logic              sw_rvalid,
  input  logic              dbg_req,
  input  logic              dbg_we,
  input  logic              dbg_sel,
  input  logic [LANE_W-1:0] dbg_wdata,
  output logic [LANE_W-1:0] dbg_rdata,
  output logic              dbg_rvalid
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RPW = AW + LSEL_W;

  logic [NPORT-1:0]  p_req, p_we, p_frz, p_re, p_rvalid;
  reg_sel_e          p_sel   [NPORT];
  logic [LANE_W-1:0] p_wdata [NPORT];
  logic [LANE_W-1:0] p_rdata [NPORT];
  logic [AW-1:0]     p_raddr [NPORT];
  logic [REC_W-1:0]  p_q     [NPORT];

  logic          frozen;
  logic [AW-1:0] wptr;
  logic [31:0]   wfield;

  assign p_req[0]   = sw_req;
  assign p_we[0]    = sw_we;
  assign p_sel[0]   = reg_sel_e'(sw_sel);
  assign p_wdata[0] = sw_wdata;
  assign p_req[1]   = dbg_req;
  assign p_we[1]    = dbg_we;
  assign p_sel[1]   = reg_sel_e'(dbg_sel);
  assign p_wdata[1] = dbg_wdata;

  assign sw_rdata   = p_rdata[0];
  assign sw_rvalid  = p_rvalid[0];
  assign dbg_rdata  = p_rdata[1];
  assign dbg_rvalid = p_rvalid[1];

  // either master holds the log still
  assign frozen = |p_frz;

  trace_log_wptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk(clk), .rst(rst), .hold(frozen), .wptr(wptr), .wfield(wfield)
  );

  generate
    for (genvar m = 0; m < NPORT; m++) begin : g_port
      trace_log_port #(.AW(AW), .RPW(RPW)) u_port (
        .clk(clk), .rst(rst), .req(p_req[m]), .we(p_we[m]), .sel(p_sel[m]),
        .wdata(p_wdata[m]), .wfield(wfield), .ram_q(p_q[m]), .frz(p_frz[m]),
        .ram_re(p_re[m]), .ram_raddr(p_raddr[m]), .rdata(p_rdata[m]),
        .rvalid(p_rvalid[m])
      );
      if (DEPTH > 0) begin : g_ram
        // one copy per reader, all written with the same record
        trace_log_ram #(.WORDS(DEPTH), .AW(AW), .DW(REC_W)) u_ram (
          .clk(clk), .we(!frozen), .waddr(wptr), .wdata(rec_in),
          .re(p_re[m]), .raddr(p_raddr[m]), .rdata(p_q[m])
        );
      end else begin : g_noram
        logic unused_rd;
        assign unused_rd = p_re[m] ^ (^p_raddr[m]) ^ (^rec_in);
        assign p_q[m] = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/trace_ring_log_chk.sv
module trace_ring_log_chk #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          frozen,
  input logic [AW-1:0] wptr,
  input logic          sw_req,
  input logic          sw_we,
  input logic          sw_sel,
  input logic [63:0]   sw_wdata,
  input logic [63:0]   sw_rdata,
  input logic          sw_rvalid,
  input logic          dbg_req,
  input logic          dbg_we,
  input logic          dbg_rvalid
);
  localparam int LOGD = (DEPTH > 1) ? $clog2(DEPTH) : 0;
  logic unused_c;
  assign unused_c = ^sw_wdata;

  // R10: reset clears flags and valids
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (!sw_rvalid && !dbg_rvalid && !frozen));

  // R7: read response timing on both ports
  a_r7_sw_rvalid: assert property (@(posedge clk) disable iff (rst)
    (sw_req && !sw_we) |=> sw_rvalid);
  a_r7_sw_quiet: assert property (@(posedge clk) disable iff (rst)
    !(sw_req && !sw_we) |=> !sw_rvalid);
  a_r7_dbg_rvalid: assert property (@(posedge clk) disable iff (rst)
    (dbg_req && !dbg_we) |=> dbg_rvalid);

  // R6: a software freeze write holds the log on the next cycle
  a_r6_sw_freeze: assert property (@(posedge clk) disable iff (rst)
    (sw_req && sw_we && !sw_sel && sw_wdata[31]) |=> frozen);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(wptr));

  generate
    if (DEPTH > 0) begin : g_on
      // R1: pointer steps and wraps while logging
      a_r1_wptr_step: assert property (@(posedge clk) disable iff (rst)
        !frozen |=> (wptr == (($past(wptr) == AW'(DEPTH - 1)) ? '0 : $past(wptr) + 1'b1)));
      // R2: highest set bit of the write field encodes the length
      a_r2_len_bit: assert property (@(posedge clk) disable iff (rst)
        (sw_req && !sw_we && !sw_sel) |=> ((sw_rdata[63:32] >> LOGD) == 32'd1));
    end else begin : g_off
      // R9: disabled log reports a zero write field
      a_r9_zero_field: assert property (@(posedge clk) disable iff (rst)
        (sw_req && !sw_we && !sw_sel) |=> (sw_rdata[63:32] == 32'd0));
    end
  endgenerate
endmodule

bind trace_ring_log trace_ring_log_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .frozen(frozen), .wptr(wptr),
  .sw_req(sw_req), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
  .sw_rdata(sw_rdata), .sw_rvalid(sw_rvalid),
  .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_rvalid(dbg_rvalid)
);

// File: tb/trace_ring_log_tb.sv
module trace_ring_log_tb;
  localparam int D  = 8;
  localparam int RW = 4 * D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(negedge clk) cyc <= cyc + 1;

  function automatic logic [255:0] mk(input int n);
    logic [255:0] r;
    for (int j = 0; j < 4; j++)
      r[64*j +: 64] = {8'(8'hA0 + j), 24'(n), 32'(n * 13 + j * 101)};
    return r;
  endfunction

  logic [255:0] rec_in;
  assign rec_in = mk(cyc);

  logic        s_req = 0, s_we = 0, s_sel = 0, d_req = 0, d_we = 0, d_sel = 0;
  logic [63:0] s_wd = 0, d_wd = 0, s_rd, d_rd;
  logic        s_rv, d_rv;
  logic        o_req = 0, o_we = 0, o_sel = 0;
  logic [63:0] o_wd = 0, o_rd, o_drd;
  logic        o_rv, o_drv;

  trace_ring_log #(.DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .rec_in(rec_in),
    .sw_req(s_req), .sw_we(s_we), .sw_sel(s_sel), .sw_wdata(s_wd),
    .sw_rdata(s_rd), .sw_rvalid(s_rv),
    .dbg_req(d_req), .dbg_we(d_we), .dbg_sel(d_sel), .dbg_wdata(d_wd),
    .dbg_rdata(d_rd), .dbg_rvalid(d_rv)
  );

  trace_ring_log #(.DEPTH(0)) u_dut_off (
    .clk(clk), .rst(rst), .rec_in(rec_in),
    .sw_req(o_req), .sw_we(o_we), .sw_sel(o_sel), .sw_wdata(o_wd),
    .sw_rdata(o_rd), .sw_rvalid(o_rv),
    .dbg_req(1'b0), .dbg_we(1'b0), .dbg_sel(1'b0), .dbg_wdata(64'd0),
    .dbg_rdata(o_drd), .dbg_rvalid(o_drv)
  );

  // model of the log contents, built from the requirements
  logic [255:0] m_mem [D];
  int m_wp = 0;
  bit m_fs = 0, m_fd = 0;
  int s_rp = 0, d_rp = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_wp = 0; m_fs = 0; m_fd = 0;
    end else begin
      if (!(m_fs || m_fd)) begin
        m_mem[m_wp] = mk(cyc);
        m_wp = (m_wp + 1) % D;
      end
      if (s_req && s_we && !s_sel) m_fs = s_wd[31];
      if (d_req && d_we && !d_sel) m_fd = d_wd[31];
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] lane_at(input int rp);
    return m_mem[(rp / 4) % D][64*(rp % 4) +: 64];
  endfunction

  function automatic logic [63:0] ctl_exp(input int wp, input bit f, input int rp);
    return {32'(D | wp), f, 31'(rp)};
  endfunction

  // one access; called just after a negedge, returns just after the next one
  task automatic acc(input int p, input bit we, input bit sel, input logic [63:0] wd,
                     output logic [63:0] rd, output logic rv, output int wp_now);
    wp_now = m_wp;
    case (p)
      0: begin s_req = 1; s_we = we; s_sel = sel; s_wd = wd; end
      1: begin d_req = 1; d_we = we; d_sel = sel; d_wd = wd; end
      default: begin o_req = 1; o_we = we; o_sel = sel; o_wd = wd; end
    endcase
    @(negedge clk);
    case (p)
      0: begin rd = s_rd; rv = s_rv; s_req = 0; end
      1: begin rd = d_rd; rv = d_rv; d_req = 0; end
      default: begin rd = o_rd; rv = o_rv; o_req = 0; end
    endcase
  endtask

  task automatic data_rd(input int p, input string req);
    logic [63:0] rd; logic rv; int wp;
    int rp;
    rp = (p == 0) ? s_rp : d_rp;
    acc(p, 0, 1, 64'd0, rd, rv, wp);
    chk(req, {63'd0, rv}, 64'd1);
    chk(req, rd, lane_at(rp));
    if (p == 0) s_rp = (s_rp + 1) % RW; else d_rp = (d_rp + 1) % RW;
  endtask

  task automatic ctl_wr(input int p, input bit f, input int rp, input logic [31:0] hi);
    logic [63:0] rd; logic rv; int wp;
    acc(p, 1, 0, {hi, f, 31'(rp)}, rd, rv, wp);
    chk("R7 no valid after write", {63'd0, rv}, 64'd0);
    if (p == 0) s_rp = rp % RW; else d_rp = rp % RW;
  endtask

  initial begin
    logic [63:0] rd, rd2; logic rv; int wp, wp0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R10 sw_rvalid after reset", {63'd0, s_rv}, 64'd0);
    chk("R10 dbg_rvalid after reset", {63'd0, d_rv}, 64'd0);
    acc(0, 0, 0, 64'd0, rd, rv, wp);
    chk("R10 R2 control after reset", rd, ctl_exp(wp, 0, 0));

    repeat (12) @(negedge clk);
    // freeze through software, upper half carries junk (R5)
    ctl_wr(0, 1, 0, 32'hFFFF_FFFF);
    acc(0, 0, 0, 64'd0, rd, rv, wp);
    chk("R2 R3 R5 control while frozen", rd, ctl_exp(wp, 1, 0));
    repeat (5) @(negedge clk);
    acc(0, 0, 0, 64'd0, rd2, rv, wp);
    chk("R6 write field stable while frozen", rd2, rd);

    // R4: walk every doubleword and past the wrap
    for (int i = 0; i < RW + 2; i++) data_rd(0, "R4 R3 sequential read");

    // R5: cursor load sweep, including values beyond 4*DEPTH
    for (int r = 0; r < RW + 8; r++) begin
      ctl_wr(0, 1, r, 32'hDEAD_BEEF);
      data_rd(0, "R5 R3 loaded cursor read");
    end

    // R5: data register writes have no effect
    ctl_wr(0, 1, 5, 32'd0);
    acc(0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, rd, rv, wp);
    acc(0, 0, 0, 64'd0, rd, rv, wp);
    chk("R5 data write ignored", rd, ctl_exp(wp, 1, 5));
    data_rd(0, "R5 read after ignored write");

    // R6: freeze held by debug after software releases
    ctl_wr(1, 1, 0, 32'd0);
    ctl_wr(0, 0, 0, 32'd0);
    acc(0, 0, 0, 64'd0, rd, rv, wp0);
    repeat (6) @(negedge clk);
    acc(0, 0, 0, 64'd0, rd2, rv, wp);
    chk("R6 debug flag alone holds log", rd2, rd);
    acc(1, 0, 0, 64'd0, rd, rv, wp);
    chk("R8 debug keeps own flag", rd, ctl_exp(wp, 1, 0));

    // R6: release, three idle edges, then software freeze on a storing edge
    ctl_wr(1, 0, 0, 32'd0);
    repeat (3) @(negedge clk);
    ctl_wr(0, 1, 0, 32'd0);
    acc(0, 0, 0, 64'd0, rd, rv, wp);
    chk("R6 R1 four records after release", rd, ctl_exp((wp0 + 4) % D, 1, 0));
    for (int i = 0; i < RW; i++) data_rd(0, "R1 R6 contents after release");

    // R8: both ports read in the same cycles
    ctl_wr(0, 1, 3, 32'd0);
    ctl_wr(1, 0, 17, 32'd0);
    for (int i = 0; i < 6; i++) begin
      s_req = 1; s_we = 0; s_sel = 1;
      d_req = 1; d_we = 0; d_sel = 1;
      @(negedge clk);
      chk("R8 sw concurrent read", s_rd, lane_at(s_rp));
      chk("R8 dbg concurrent read", d_rd, lane_at(d_rp));
      chk("R8 both valid", {62'd0, s_rv, d_rv}, 64'd3);
      s_req = 0; d_req = 0;
      s_rp = (s_rp + 1) % RW; d_rp = (d_rp + 1) % RW;
    end

    // R9: disabled log
    acc(2, 0, 0, 64'd0, rd, rv, wp);
    chk("R9 zero write field", {32'd0, rd[63:32]}, 64'd0);
    acc(2, 0, 1, 64'd0, rd, rv, wp);
    chk("R9 zero data", rd, 64'd0);
    chk("R9 R7 data valid", {63'd0, rv}, 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule